// File: doc/BRIEF.md
# Multi-Mode Register Shift Unit

This block carries out the shift operation of a 32-bit processor whose bit numbering puts the most significant bit first. It takes three inputs: an effective control word, an optional index word, and one or two register operands. It produces the shifted register contents and a set of flags. Four shift families are supported, and each can work on a single register or on a register pair: zero-fill logical, rotate, sign-aware arithmetic, and a leading-one seek. The result reaches the outputs one clock after the request.

The control word holds two fields. A 3-bit type field picks the family and the width. A 7-bit two's-complement count gives the direction and the distance. When indexing is requested, the low seven bits of the index word are added to the count. The type field is never changed by indexing. All other control bits are ignored.

In pair mode, an even register number joins R (upper half) and R+1 (lower half) into one 64-bit value. An odd register number places R in both halves, and only the upper half of the result is meant to be written back. On left shifts the unit reports two flags. The first is an overflow flag for any change of the top bit of R during the shift. The second is the parity of the 1s pushed out of the top of R. The seek family also reports whether a 1 reached the top and how much of the count was left unused.

Top module: `shift_unit`

## Requirements
- R1: A request accepted with `in_valid` high appears on all result outputs on the next rising edge, and `out_valid` is high for exactly that cycle. With `in_valid` low the result outputs hold. After reset all outputs are zero.
- R2: The type field is `ctrl_word[10:8]`. Bits 10:9 select the family: 00 logical, 01 rotate, 10 arithmetic, 11 seek. Bit 8 selects pair mode (1) or single mode (0). Bits 31:11 and bit 7 of `ctrl_word` have no effect on any output.
- R3: The count is `ctrl_word[6:0]` read as a signed value from -64 to +63. When `use_index` is 1, `index_word[6:0]` is added to it modulo 128. A count of zero or more shifts left by that amount, and a negative count shifts right by its magnitude.
- R4: Logical shifts fill vacated positions with zeros in both directions.
- R5: Rotate shifts feed each bit that leaves one end back into the other end, for any count, including counts larger than the operand width.
- R6: Arithmetic right shifts fill with copies of the operand's top bit. Arithmetic left shifts fill with zeros.
- R7: In pair mode with `odd_reg` = 0, the operand is {`reg_hi`,`reg_lo`}. The result comes out as `res_hi` (upper) and `res_lo` (lower), and `res_lo_we` is 1. In single mode `res_lo_we` is 0 and the 32-bit result appears on `res_hi`.
- R8: In pair mode with `odd_reg` = 1, the operand is {`reg_hi`,`reg_hi`}, the upper 32 result bits appear on `res_hi`, and `res_lo_we` is 0.
- R9: `overflow` is 1 when the top bit of R changes at any single-position step of a left or seek shift. It is always 0 for right shifts.
- R10: For logical, rotate and arithmetic shifts with a count of zero or more, `cc_parity` is the parity of the 1s shifted out of the top of R (1 means odd). For right shifts and all seek shifts, `cc_parity` equals `parity_in`.
- R11: A seek shift rotates left one position at a time. It stops as soon as the top bit of R is 1 or the count runs out, and a negative count is treated as zero. `cc_found` is 1 when the top bit ended at 1. `seek_rem` is the unused part of the count when found, and 0 otherwise. For every non-seek shift both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| ctrl_word | input | 32 | Effective control word (type and count fields) |
| use_index | input | 1 | Add index count to the control count |
| index_word | input | 32 | Index register contents |
| odd_reg | input | 1 | Register number of R is odd |
| reg_hi | input | 32 | Contents of register R |
| reg_lo | input | 32 | Contents of register R+1 |
| parity_in | input | 1 | Current parity condition bit, kept when not updated |
| out_valid | output | 1 | Result valid |
| res_hi | output | 32 | New contents of R |
| res_lo | output | 32 | New contents of R+1 |
| res_lo_we | output | 1 | R+1 should be written |
| overflow | output | 1 | Top bit of R changed during a left shift |
| cc_parity | output | 1 | Parity of ejected 1s |
| cc_found | output | 1 | Seek ended with a 1 in the top bit |
| seek_rem | output | 7 | Count left over from a seek |

## Verification
Random requests mix all eight type codes, counts across the full signed range, and both settings of indexing and register parity. Operands are either dense or right-shifted into sparse words, so that seek shifts both hit and miss. A bench model steps the shift one position at a time, which separates fill rules and wraparound from a one-step barrel calculation. Directed cases cover the extremes: a count of -64 on a negative pair, an index sum that wraps to a negative count, a zero operand under seek, an odd register in pair mode, and a request repeated with only the ignored control bits changed.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
    localparam int SU_WORD_W = 32;
    localparam int SU_CNT_W  = 7;

    typedef enum logic [1:0] {
        FAM_LOGIC  = 2'b00,
        FAM_ROTATE = 2'b01,
        FAM_ARITH  = 2'b10,
        FAM_SEEK   = 2'b11
    } shift_fam_e;

    typedef struct packed {
        shift_fam_e           fam;
        logic                 pair;
        logic [SU_CNT_W-1:0]  cnt;
    } shift_ctl_t;

    typedef struct packed {
        logic                   vld;
        logic [2*SU_WORD_W-1:0] res;
        logic                   wr_lo;
        logic                   ovf;
        logic                   par;
        logic                   found;
        logic [SU_CNT_W-1:0]    rem;
    } shift_state_t;
endpackage

// File: rtl/su_ctrl_decode.sv
module su_ctrl_decode
    import shift_unit_pkg::*;
#(
    parameter int WORD_W = SU_WORD_W,
    parameter int CNT_W  = SU_CNT_W
) (
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic              use_index,
    input  logic [WORD_W-1:0] index_word,
    output shift_ctl_t        ctl
);
    // type field sits three bits above an unused gap over the count
    localparam int TYPE_LSB = WORD_W - 24;

    logic [CNT_W-1:0] idx_part;
    logic             unused_bits;

    assign unused_bits = ^{ctrl_word[WORD_W-1:TYPE_LSB+3],
                           ctrl_word[TYPE_LSB-1:CNT_W],
                           index_word[WORD_W-1:CNT_W]};

    always_comb begin
        idx_part = use_index ? index_word[CNT_W-1:0] : '0;
        ctl.fam  = shift_fam_e'(ctrl_word[TYPE_LSB+2 -: 2]);
        ctl.pair = ctrl_word[TYPE_LSB];
        ctl.cnt  = ctrl_word[CNT_W-1:0] + idx_part;   // wraps modulo 2**CNT_W
    end
endmodule

// File: rtl/su_operand_form.sv
module su_operand_form #(
    parameter int WORD_W = 32
) (
    input  logic                  pair,
    input  logic                  odd_reg,
    input  logic [WORD_W-1:0]     reg_hi,
    input  logic [WORD_W-1:0]     reg_lo,
    output logic [2*WORD_W-1:0]   opnd,
    output logic                  wr_lo
);
    always_comb begin
        if (!pair)
            opnd = {reg_hi, {WORD_W{1'b0}}};
        else if (odd_reg)
            opnd = {reg_hi, reg_hi};
        else
            opnd = {reg_hi, reg_lo};
        wr_lo = pair & ~odd_reg;
    end
endmodule

// File: rtl/su_shift_core.sv
module su_shift_core
    import shift_unit_pkg::*;
#(
    parameter int WORD_W = SU_WORD_W,
    parameter int CNT_W  = SU_CNT_W
) (
    input  shift_ctl_t            ctl,
    input  logic [2*WORD_W-1:0]   opnd,
    input  logic                  par_in,
    output logic [2*WORD_W-1:0]   res,
    output logic                  ovf,
    output logic                  par,
    output logic                  found,
    output logic [CNT_W-1:0]      rem
);
    localparam int DW    = 2 * WORD_W;
    localparam int SW    = 4 * WORD_W;
    localparam int REPS  = SW / WORD_W;
    localparam int AMT_W = CNT_W + 1;

    function automatic logic [AMT_W-1:0] lead_zeros(input logic [DW-1:0] v);
        int  n;
        logic hit;
        n   = 0;
        hit = 1'b0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + 1;
            end
        end
        return AMT_W'(n);
    endfunction

    logic [WORD_W-1:0] hi_w;
    logic              neg, is_seek, go_left, seek_hit, nz;
    logic [CNT_W-1:0]  mag;
    logic [AMT_W-1:0]  eff, lz, amt_l;
    logic [SW-1:0]     sl, sr, shl, shr, win_mask, ej_mask, win;

    always_comb begin
        hi_w    = opnd[DW-1 -: WORD_W];
        neg     = ctl.cnt[CNT_W-1];
        mag     = neg ? -ctl.cnt : ctl.cnt;
        is_seek = (ctl.fam == FAM_SEEK);
        go_left = is_seek | ~neg;

        // seek distance from a leading-zero count instead of stepping
        nz       = |opnd;
        lz       = lead_zeros(ctl.pair ? opnd : {hi_w, {WORD_W{1'b1}}});
        eff      = neg ? '0 : {1'b0, ctl.cnt};
        seek_hit = nz && (lz <= eff);
        amt_l    = is_seek ? (seek_hit ? lz : eff) : {1'b0, mag};

        // left-justified stream: operand followed by what shifts in
        if (ctl.fam == FAM_ROTATE || is_seek)
            sl = ctl.pair ? {(REPS/2){opnd}} : {REPS{hi_w}};
        else
            sl = ctl.pair ? {opnd, {DW{1'b0}}} : {hi_w, {(SW-WORD_W){1'b0}}};

        // right-justified stream: what shifts in, then the operand
        case (ctl.fam)
            FAM_ROTATE: sr = sl;
            FAM_ARITH:  sr = ctl.pair ? {{(SW-DW){opnd[DW-1]}}, opnd}
                                      : {{(SW-WORD_W){hi_w[WORD_W-1]}}, hi_w};
            default:    sr = ctl.pair ? {{(SW-DW){1'b0}}, opnd}
                                      : {{(SW-WORD_W){1'b0}}, hi_w};
        endcase

        shl      = sl << amt_l;
        shr      = sr >> mag;
        win_mask = ~({SW{1'b1}} >> (amt_l + AMT_W'(1)));
        ej_mask  = ~({SW{1'b1}} >> amt_l);
        win      = sl & win_mask;

        if (go_left)
            res = ctl.pair ? shl[SW-1 -: DW] : {shl[SW-1 -: WORD_W], {WORD_W{1'b0}}};
        else
            res = ctl.pair ? shr[DW-1:0] : {shr[WORD_W-1:0], {WORD_W{1'b0}}};

        ovf   = go_left & (|win) & (win != win_mask);
        par   = (go_left && !is_seek) ? ^(sl & ej_mask) : par_in;
        found = is_seek & seek_hit;
        rem   = found ? CNT_W'(eff - lz) : '0;
    end

    always_comb begin
        AST_SEEK_LANDS_ONE: assert (!(is_seek && seek_hit) || res[DW-1]); // R11
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_unit_pkg::*;
#(
    parameter int WORD_W = SU_WORD_W,
    parameter int CNT_W  = SU_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic              use_index,
    input  logic [WORD_W-1:0] index_word,
    input  logic              odd_reg,
    input  logic [WORD_W-1:0] reg_hi,
    input  logic [WORD_W-1:0] reg_lo,
    input  logic              parity_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo,
    output logic              res_lo_we,
    output logic              overflow,
    output logic              cc_parity,
    output logic              cc_found,
    output logic [CNT_W-1:0]  seek_rem
);
    localparam int TYPE_LSB = WORD_W - 24;
    localparam int DW       = 2 * WORD_W;

    shift_ctl_t       ctl;
    logic [DW-1:0]    opnd, core_res;
    logic             wr_lo, core_ovf, core_par, core_found;
    logic [CNT_W-1:0] core_rem;
    shift_state_t     st_d, st_q;

    su_ctrl_decode #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_decode (
        .ctrl_word (ctrl_word),
        .use_index (use_index),
        .index_word(index_word),
        .ctl       (ctl)
    );

    su_operand_form #(.WORD_W(WORD_W)) u_form (
        .pair   (ctl.pair),
        .odd_reg(odd_reg),
        .reg_hi (reg_hi),
        .reg_lo (reg_lo),
        .opnd   (opnd),
        .wr_lo  (wr_lo)
    );

    su_shift_core #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_core (
        .ctl   (ctl),
        .opnd  (opnd),
        .par_in(parity_in),
        .res   (core_res),
        .ovf   (core_ovf),
        .par   (core_par),
        .found (core_found),
        .rem   (core_rem)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res   = core_res;
            st_d.wr_lo = wr_lo;
            st_d.ovf   = core_ovf;
            st_d.par   = core_par;
            st_d.found = core_found;
            st_d.rem   = core_rem;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign res_hi    = st_q.res[DW-1 -: WORD_W];
    assign res_lo    = st_q.res[WORD_W-1:0];
    assign res_lo_we = st_q.vld & st_q.wr_lo;
    assign overflow  = st_q.ovf;
    assign cc_parity = st_q.par;
    assign cc_found  = st_q.found;
    assign seek_rem  = st_q.rem;

    AST_OUT_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_hi) && $stable(cc_parity) && !out_valid); // R1
    AST_SINGLE_NO_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !ctrl_word[TYPE_LSB] |=> !res_lo_we); // R7
    AST_ODD_NO_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && odd_reg |=> !res_lo_we); // R8
    AST_RIGHT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !use_index && ctrl_word[CNT_W-1]
        && ctrl_word[TYPE_LSB+2 -: 2] != 2'b11 |=> !overflow); // R9
    AST_SEEK_KEEPS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ctrl_word[TYPE_LSB+2 -: 2] == 2'b11 |=> cc_parity == $past(parity_in)); // R10
endmodule

// File: tb/tb_shift_unit.sv
`timescale 1ns/1ps
module tb_shift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        use_index = 1'b0;
    logic [31:0] index_word = '0;
    logic        odd_reg = 1'b0;
    logic [31:0] reg_hi = '0;
    logic [31:0] reg_lo = '0;
    logic        parity_in = 1'b0;
    logic        out_valid, res_lo_we, overflow, cc_parity, cc_found;
    logic [31:0] res_hi, res_lo;
    logic [6:0]  seek_rem;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shift_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl_word(ctrl_word),
        .use_index(use_index), .index_word(index_word), .odd_reg(odd_reg),
        .reg_hi(reg_hi), .reg_lo(reg_lo), .parity_in(parity_in),
        .out_valid(out_valid), .res_hi(res_hi), .res_lo(res_lo),
        .res_lo_we(res_lo_we), .overflow(overflow), .cc_parity(cc_parity),
        .cc_found(cc_found), .seek_rem(seek_rem)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [2:0] typ, input logic [6:0] cnt,
                                            input logic [31:0] junk);
        return (junk & ~32'h0000_077F) | {21'd0, typ, 1'b0, cnt};
    endfunction

    // step-by-step model of the shift
    task automatic model(input logic [31:0] cw, input logic ui, input logic [31:0] iw,
                         input logic od, input logic [31:0] h, input logic [31:0] l,
                         input logic pin,
                         output logic [31:0] e_hi, output logic [31:0] e_lo,
                         output logic e_we, output logic e_ov, output logic e_par,
                         output logic e_fnd, output logic [6:0] e_rem);
        logic [2:0]  typ;
        logic [6:0]  c;
        int          cnt, lsb, k;
        logic        dbl, o, lb, sg;
        logic [1:0]  fam;
        logic [63:0] v;
        typ = cw[10:8];
        c   = cw[6:0] + (ui ? iw[6:0] : 7'd0);
        cnt = int'($signed(c));
        dbl = typ[0];
        fam = typ[2:1];
        v   = dbl ? {h, (od ? h : l)} : {h, 32'd0};
        lsb = dbl ? 0 : 32;
        e_ov = 1'b0; e_par = 1'b0; e_fnd = 1'b0; e_rem = '0;
        if (fam == 2'b11) begin
            k = 0;
            while (k < cnt && !v[63]) begin
                o = v[63];
                v = v << 1;
                if (!dbl) v[31:0] = '0;
                v[lsb] = o;
                if (v[63] != o) e_ov = 1'b1;
                k++;
            end
            e_fnd = v[63];
            e_rem = (e_fnd && cnt > 0) ? 7'(cnt - k) : 7'd0;
            e_par = pin;
        end else if (cnt >= 0) begin
            for (int i = 0; i < cnt; i++) begin
                o = v[63];
                v = v << 1;
                if (!dbl) v[31:0] = '0;
                v[lsb] = (fam == 2'b01) ? o : 1'b0;
                if (v[63] != o) e_ov = 1'b1;
                e_par = e_par ^ o;
            end
        end else begin
            for (int i = 0; i < -cnt; i++) begin
                lb = v[lsb];
                sg = v[63];
                v  = v >> 1;
                if (!dbl) v[31:0] = '0;
                v[63] = (fam == 2'b01) ? lb : (fam == 2'b10) ? sg : 1'b0;
            end
            e_par = pin;
        end
        e_hi = v[63:32];
        e_lo = v[31:0];
        e_we = dbl & ~od;
    endtask

    task automatic run(input string tag, input logic [31:0] cw, input logic ui,
                       input logic [31:0] iw, input logic od, input logic [31:0] h,
                       input logic [31:0] l, input logic pin);
        logic [31:0] e_hi, e_lo;
        logic        e_we, e_ov, e_par, e_fnd;
        logic [6:0]  e_rem;
        string       ft;
        model(cw, ui, iw, od, h, l, pin, e_hi, e_lo, e_we, e_ov, e_par, e_fnd, e_rem);
        @(negedge clk);
        ctrl_word = cw; use_index = ui; index_word = iw; odd_reg = od;
        reg_hi = h; reg_lo = l; parity_in = pin; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        case (cw[10:9])
            2'b00:   ft = "R4";
            2'b01:   ft = "R5";
            2'b10:   ft = "R6";
            default: ft = "R11";
        endcase
        chk({tag, " R1 out_valid"}, 64'(out_valid), 64'd1);
        chk({tag, " ", ft, " R3 res_hi"}, 64'(res_hi), 64'(e_hi));
        if (e_we) chk({tag, " R7 res_lo"}, 64'(res_lo), 64'(e_lo));
        chk({tag, (cw[8] ? (od ? " R8" : " R7") : " R7"), " res_lo_we"}, 64'(res_lo_we), 64'(e_we));
        chk({tag, " R9 overflow"}, 64'(overflow), 64'(e_ov));
        chk({tag, " R10 cc_parity"}, 64'(cc_parity), 64'(e_par));
        chk({tag, " R11 cc_found"}, 64'(cc_found), 64'(e_fnd));
        chk({tag, " R11 seek_rem"}, 64'(seek_rem), 64'(e_rem));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] h, l, cw, keep_hi;
        logic        keep_par;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset out_valid", 64'(out_valid), 64'd0);
        chk("R1 reset res_hi", 64'(res_hi), 64'd0);
        chk("R1 reset overflow", 64'(overflow), 64'd0);
        rst_n = 1'b1;

        // directed corner cases
        run("R4 logical left", mk_ctrl(3'b000, 7'd4, 0), 0, 0, 0, 32'h8000_0001, 0, 0);
        run("R6 arith pair -64", mk_ctrl(3'b101, 7'h40, 0), 0, 0, 0, 32'h8000_0000, 32'h1234_5678, 0);
        run("R3 index wraps", mk_ctrl(3'b010, 7'd60, 0), 1, 32'hFFFF_FF0A, 0, 32'hDEAD_BEEF, 0, 1);
        run("R8 odd rotate pair", mk_ctrl(3'b011, 7'd40, 0), 0, 0, 1, 32'hF000_000F, 32'h5555_5555, 0);
        run("R11 seek zero", mk_ctrl(3'b111, 7'd63, 0), 0, 0, 0, 0, 0, 1);
        run("R11 seek single hit", mk_ctrl(3'b110, 7'd20, 0), 0, 0, 0, 32'h0001_0000, 0, 0);
        run("R11 seek negative", mk_ctrl(3'b110, 7'h7E, 0), 0, 0, 0, 32'h0000_0100, 0, 1);
        run("R5 rotate single 63", mk_ctrl(3'b010, 7'd63, 0), 0, 0, 0, 32'h8000_0003, 0, 0);
        run("R9 arith left ovf", mk_ctrl(3'b100, 7'd1, 0), 0, 0, 0, 32'h4000_0000, 0, 0);

        // R2: same request with only ignored control bits changed
        run("R2 ignored bits a", mk_ctrl(3'b001, 7'd9, 32'h0000_0000), 0, 0, 0, 32'h0F0F_1234, 32'h8765_4321, 0);
        keep_hi = res_hi;
        keep_par = cc_parity;
        run("R2 ignored bits b", mk_ctrl(3'b001, 7'd9, 32'hFFFF_F8FF), 0, 0, 0, 32'h0F0F_1234, 32'h8765_4321, 0);
        chk("R2 res_hi unchanged by ignored bits", 64'(res_hi), 64'(keep_hi));
        chk("R2 cc_parity unchanged by ignored bits", 64'(cc_parity), 64'(keep_par));

        // R1 hold while idle
        keep_hi = res_hi;
        repeat (3) @(negedge clk);
        chk("R1 idle out_valid", 64'(out_valid), 64'd0);
        chk("R1 idle res_hi holds", 64'(res_hi), 64'(keep_hi));

        // constrained random
        for (int n = 0; n < 800; n++) begin
            h = $urandom;
            l = $urandom;
            if ($urandom % 3 == 0) h = h >> ($urandom % 32);
            if ($urandom % 3 == 0) l = l >> ($urandom % 32);
            if ($urandom % 16 == 0) h = '0;
            cw = $urandom;
            run("rand", cw, 1'($urandom), $urandom, 1'($urandom), h, l, 1'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule